// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Generator

This block is the part of an I2C master that creates the bus framing events. A single write to the control register asks for either a START or a STOP. The write carries three bits: master select, transmit select and bus-busy. The block then times each phase of the event with one down-counter, and drives the SCL and SDA lines through open-drain pull-down enables. A drive enable of 1 pulls its line low. A drive enable of 0 releases the line, so the pull-up holds it high.

After a START, the block pulses a clear to the bit counter. It then asks the shift logic to clock out the slave-address byte, which must already be loaded, and waits for the shifter to report that the byte is done. A STOP releases SDA while SCL is free, and then holds off for a recovery interval before the block accepts a new request. Each setup and hold interval is a fixed count of system clocks. The count depends on the speed mode, which is captured when the request is accepted.

Top module: `i2c_cond_gen`

## Requirements
- R1: During and after reset, and whenever no event is in progress, scl_drv, sda_drv, bitcnt_clr and byte_req are all 0.
- R2: A START is accepted only from idle and only when all of these hold in the same strobed write: en=1, busy=0, addr_loaded=1, wr_mst=1, wr_trx=1, wr_bb=1. If any of them is missing, the write leaves every output at 0.
- R3: In standard mode (fast=0), a START keeps both drive enables at 0 for 20 cycles after the accepting edge. It then sets sda_drv=1 with scl_drv=0 for 20 cycles.
- R4: In high-speed mode (fast=1), the same two START phases last 10 cycles each.
- R5: After the START hold phase, there is exactly one cycle with scl_drv=1, sda_drv=1 and bitcnt_clr=1. The block then raises byte_req with both drive enables at 0, keeps byte_req high until byte_done=1, and returns to idle on the next edge.
- R6: A STOP is accepted from idle when en=1, wr_mst=1, wr_trx=1 and wr_bb=0 in one strobed write, whatever the level of busy.
- R7: In standard mode, a STOP sets sda_drv=1 with scl_drv=0 for 20 cycles. It then releases both lines for 18 cycles, and a START write made during those cycles is ignored.
- R8: In high-speed mode, the STOP setup lasts 12 cycles and the STOP hold lasts 10 cycles.
- R9: A write with any other bit pattern, or any write made while an event is in progress, has no effect on the outputs or on the phase lengths.
- R10: The speed mode is sampled when a request is accepted. Changing fast while the event runs does not change its phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Module enable |
| fast | input | 1 | Speed mode: 1 high-speed, 0 standard |
| wr_stb | input | 1 | Control register write strobe |
| wr_mst | input | 1 | Write data: master select |
| wr_trx | input | 1 | Write data: transmit select |
| wr_bb | input | 1 | Write data: bus-busy bit |
| busy | input | 1 | Current bus-busy flag |
| addr_loaded | input | 1 | Slave address present in the shift register |
| byte_done | input | 1 | Shifter finished the address byte |
| scl_drv | output | 1 | Pull SCL low when 1 |
| sda_drv | output | 1 | Pull SDA low when 1 |
| bitcnt_clr | output | 1 | One-cycle clear of the bit counter |
| byte_req | output | 1 | Request to the shifter to send one byte |

## Verification
A START is run in each speed mode. The bench counts the released cycles before SDA is pulled and the cycles SDA stays pulled while SCL is free, so a wrong length in either phase or either mode shows up as a distinct count. A STOP is run in each mode, once with busy high. A START write is placed on the last cycle of the STOP hold and on the cycle after it, which fixes the hold length at the ports to the exact cycle. Near-miss writes, with one enabling bit missing at a time, are used to show that each qualifier is needed. A foreign write and a speed-mode flip are injected inside a running START to show that neither disturbs the timing.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int ST_SETUP_STD  = 20,
  parameter int ST_HOLD_STD   = 20,
  parameter int ST_SETUP_FAST = 10,
  parameter int ST_HOLD_FAST  = 10,
  parameter int SP_SETUP_STD  = 20,
  parameter int SP_HOLD_STD   = 18,
  parameter int SP_SETUP_FAST = 12,
  parameter int SP_HOLD_FAST  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  input  logic wr_stb,
  input  logic wr_mst,
  input  logic wr_trx,
  input  logic wr_bb,
  input  logic busy,
  input  logic addr_loaded,
  input  logic byte_done,
  output logic scl_drv,
  output logic sda_drv,
  output logic bitcnt_clr,
  output logic byte_req
);
  localparam int MAXA = (ST_SETUP_STD > ST_HOLD_STD) ? ST_SETUP_STD : ST_HOLD_STD;
  localparam int MAXB = (SP_SETUP_STD > SP_HOLD_STD) ? SP_SETUP_STD : SP_HOLD_STD;
  localparam int MAXC = (ST_SETUP_FAST > SP_SETUP_FAST) ? ST_SETUP_FAST : SP_SETUP_FAST;
  localparam int MAXD = (ST_HOLD_FAST > SP_HOLD_FAST) ? ST_HOLD_FAST : SP_HOLD_FAST;
  localparam int MAXAB = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAXCD = (MAXC > MAXD) ? MAXC : MAXD;
  localparam int MAXN = (MAXAB > MAXCD) ? MAXAB : MAXCD;
  localparam int CW = $clog2(MAXN + 1);

  localparam logic [CW-1:0] L_SSS = CW'(ST_SETUP_STD - 1);
  localparam logic [CW-1:0] L_SHS = CW'(ST_HOLD_STD - 1);
  localparam logic [CW-1:0] L_SSF = CW'(ST_SETUP_FAST - 1);
  localparam logic [CW-1:0] L_SHF = CW'(ST_HOLD_FAST - 1);
  localparam logic [CW-1:0] L_PSS = CW'(SP_SETUP_STD - 1);
  localparam logic [CW-1:0] L_PHS = CW'(SP_HOLD_STD - 1);
  localparam logic [CW-1:0] L_PSF = CW'(SP_SETUP_FAST - 1);
  localparam logic [CW-1:0] L_PHF = CW'(SP_HOLD_FAST - 1);

  typedef enum logic [2:0] {
    IDLE    = 3'd0,
    S_SETUP = 3'd1,
    S_HOLD  = 3'd2,
    S_CLR   = 3'd3,
    S_BYTE  = 3'd4,
    P_SETUP = 3'd5,
    P_HOLD  = 3'd6
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic fast_q;

  wire start_go = wr_stb && en && wr_mst && wr_trx && wr_bb && !busy && addr_loaded;
  wire stop_go  = wr_stb && en && wr_mst && wr_trx && !wr_bb;
  wire tick     = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      fast_q <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          if (start_go) begin
            st     <= S_SETUP;
            fast_q <= fast;
            cnt    <= fast ? L_SSF : L_SSS;
          end else if (stop_go) begin
            st     <= P_SETUP;
            fast_q <= fast;
            cnt    <= fast ? L_PSF : L_PSS;
          end
        end
        S_SETUP: begin
          if (tick) begin
            st  <= S_HOLD;
            cnt <= fast_q ? L_SHF : L_SHS;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (tick) st <= S_CLR;
          else cnt <= cnt - 1'b1;
        end
        S_CLR: st <= S_BYTE;
        S_BYTE: if (byte_done) st <= IDLE;
        P_SETUP: begin
          if (tick) begin
            st  <= P_HOLD;
            cnt <= fast_q ? L_PHF : L_PHS;
          end else cnt <= cnt - 1'b1;
        end
        P_HOLD: begin
          if (tick) st <= IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign sda_drv    = (st == S_HOLD) || (st == S_CLR) || (st == P_SETUP);
  assign scl_drv    = (st == S_CLR);
  assign bitcnt_clr = (st == S_CLR);
  assign byte_req   = (st == S_BYTE);
endmodule

module i2c_cond_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       wr_stb,
  input logic       wr_bb,
  input logic       busy,
  input logic       byte_done,
  input logic       scl_drv,
  input logic       sda_drv,
  input logic       bitcnt_clr,
  input logic       byte_req,
  input logic       fast_q,
  input logic [2:0] st
);
  // R5
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_clr |=> (!bitcnt_clr && byte_req));
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_done) |=> byte_req);
  // R5
  req_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_req) |-> $past(bitcnt_clr));
  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && wr_stb && busy && wr_bb) |=> (st == 3'd0));
  // R2
  en_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && wr_stb && !en) |=> (st == 3'd0));
  // R7
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_drv) && !$past(scl_drv)) |-> (st == 3'd6));
  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0) |=> $stable(fast_q));
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_stb(wr_stb), .wr_bb(wr_bb),
  .busy(busy), .byte_done(byte_done), .scl_drv(scl_drv), .sda_drv(sda_drv),
  .bitcnt_clr(bitcnt_clr), .byte_req(byte_req), .fast_q(fast_q), .st(st)
);

// File: tb/tb_i2c_cond_gen.sv
module tb_i2c_cond_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, fast = 1'b0, wr_stb = 1'b0, wr_mst = 1'b0, wr_trx = 1'b0, wr_bb = 1'b0;
  logic busy = 1'b0, addr_loaded = 1'b1, byte_done = 1'b0;
  logic scl_drv, sda_drv, bitcnt_clr, byte_req;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_cond_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fast(fast), .wr_stb(wr_stb),
    .wr_mst(wr_mst), .wr_trx(wr_trx), .wr_bb(wr_bb), .busy(busy),
    .addr_loaded(addr_loaded), .byte_done(byte_done), .scl_drv(scl_drv),
    .sda_drv(sda_drv), .bitcnt_clr(bitcnt_clr), .byte_req(byte_req)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int lines();
    return {30'd0, scl_drv, sda_drv} | (byte_req ? 4 : 0) | (bitcnt_clr ? 8 : 0);
  endfunction

  // one strobed write, called at a negedge, returns at the next negedge
  task automatic wr(input bit m, input bit t, input bit b);
    wr_mst = m; wr_trx = t; wr_bb = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic quiet(input string req, input string what);
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      seen |= lines();
      @(negedge clk);
    end
    chk(seen == 0, req, what, seen, 0);
  endtask

  task automatic finish_byte(input string req);
    repeat (3) @(negedge clk);
    chk(byte_req && !scl_drv && !sda_drv, req, "byte_req held until done", lines(), 4);
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    chk(lines() == 0, req, "idle after byte_done", lines(), 0);
  endtask

  task automatic run_start(input bit fm, input int es, input int eh, input bit inj, input string req);
    int s = 0, h = 0;
    fast = fm;
    wr(1, 1, 1);
    while (!sda_drv && s < 100) begin
      s++;
      if (inj && s == 3) fast = ~fast;
      if (inj && s == 5) begin wr_mst = 1; wr_trx = 1; wr_bb = 0; wr_stb = 1; end
      if (inj && s == 6) wr_stb = 0;
      @(negedge clk);
    end
    chk(s == es, req, "START setup cycles", s, es);
    while (sda_drv && !scl_drv && h < 100) begin
      h++;
      if (inj && h == 4) begin wr_mst = 1; wr_trx = 1; wr_bb = 1; wr_stb = 1; end
      if (inj && h == 5) wr_stb = 0;
      @(negedge clk);
    end
    chk(h == eh, req, "START hold cycles", h, eh);
    // R5: clear cycle
    chk(lines() == 11, "R5", "clear cycle lines", lines(), 11);
    @(negedge clk);
    chk(lines() == 4, "R5", "byte request entry", lines(), 4);
    finish_byte("R5");
  endtask

  // STOP, then START written d cycles after SDA release
  task automatic run_stop(input bit fm, input int es, input int d, input bit accept, input string req);
    int s = 0, seen = 0;
    fast = fm;
    wr(1, 1, 0);
    while (sda_drv && !scl_drv && s < 100) begin s++; @(negedge clk); end
    chk(s == es, req, "STOP setup cycles", s, es);
    busy = 1'b0;
    repeat (d) @(negedge clk);
    wr(1, 1, 1);
    for (int i = 0; i < 80 && !byte_req; i++) begin
      seen |= lines();
      @(negedge clk);
    end
    seen |= lines();
    chk(((seen & 1) != 0) == accept, req, "START after STOP hold accepted", (seen & 1), accept ? 1 : 0);
    if (byte_req) finish_byte(req);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(lines() == 0, "R1", "outputs in reset", lines(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lines() == 0, "R1", "outputs idle after reset", lines(), 0);

    run_start(0, 20, 20, 0, "R3");
    run_start(1, 10, 10, 0, "R4");
    // R9 and R10: foreign writes and mode flips mid-sequence
    run_start(0, 20, 20, 1, "R9 R10");
    run_start(1, 10, 10, 1, "R10");

    // R2: each qualifier removed in turn
    en = 0; wr(1, 1, 1); quiet("R2", "START with en=0");
    en = 1; busy = 1; wr(1, 1, 1); quiet("R2", "START while busy");
    busy = 0; addr_loaded = 0; wr(1, 1, 1); quiet("R2", "START without address");
    addr_loaded = 1; wr(0, 1, 1); quiet("R2", "START with mst=0");
    wr(1, 0, 1); quiet("R2", "START with trx=0");
    // R9: other patterns
    wr(0, 0, 0); quiet("R9", "pattern 000");
    wr(1, 0, 0); quiet("R9", "pattern 100");
    en = 0; wr(1, 1, 0); quiet("R6", "STOP with en=0");
    en = 1;

    // R7 / R8: hold boundary and setup length
    run_stop(0, 20, 17, 0, "R7");
    run_stop(0, 20, 18, 1, "R7");
    run_stop(1, 12, 9, 0, "R8");
    run_stop(1, 12, 10, 1, "R8");
    // R6: busy does not gate STOP
    busy = 1;
    run_stop(0, 20, 18, 1, "R6");
    report();
  end
endmodule